// File: doc/BRIEF.md
# Memory-Bus FIFO Endpoint

This block places a first-in first-out buffer behind one chip-select space of a processor's asynchronous external memory bus. The processor sees the FIFO as a single memory location. It writes a word to push it and reads the location to pop the oldest word. The bus controller drives an active-low chip select, an active-low write strobe and an active-low read strobe. All of them are clocked by the bus output clock, which also clocks both sides of the buffer.

A push request is the inverse of (chip select OR write strobe), and a pop request is the inverse of (chip select OR read strobe). Each bus access has a setup phase, a strobe phase and a hold phase. Every phase may be any length of one cycle or more. The block acts exactly once per strobe, on its first clock, however long the strobe lasts.

The block returns two status flags to the processors. The writer watches `full`. The reader watches `half_full` and drains the buffer in bursts. Read data is registered and stays stable until the next pop, so the processor can latch it anywhere in the strobe or hold phase.

Top module: `membus_fifo_port`

## Requirements
- R1: A push happens when `bus_cs_n`=0 and `bus_we_n`=0 are sampled together after a clock where that pair was not both low. It happens once per strobe, however many cycles the strobe lasts.
- R2: A pop happens on the first clock of a strobe where `bus_cs_n`=0 and `bus_re_n`=0. It happens once per strobe. `bus_rdata` then shows the oldest stored word, so words come out in the order they were pushed.
- R3: While `bus_cs_n`=1, toggling `bus_we_n` or `bus_re_n` changes neither the stored contents, nor the flags, nor `bus_rdata`.
- R4: A write strobe while `full`=1 is dropped. The stored words and their order are unchanged.
- R5: A read strobe while the buffer is empty is dropped. `bus_rdata` keeps its previous value and the occupancy stays zero.
- R6: `full` is 1 exactly when the occupancy equals DEPTH.
- R7: `half_full` is 1 exactly when the occupancy is at least DEPTH/2.
- R8: `bus_rdata` changes only on the clock where a pop takes place. It is stable through the rest of the strobe and through the hold phase.
- R9: After reset the buffer is empty, `full`=0, `half_full`=0 and `bus_rdata`=0.
- R10: Correct behaviour holds for every combination of setup, strobe and hold lengths of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus output clock, shared by both sides of the buffer |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select for the FIFO space |
| bus_we_n | input | 1 | Active-low write strobe |
| bus_re_n | input | 1 | Active-low read strobe |
| bus_wdata | input | DATA_W | Write data from the bus |
| bus_rdata | output | DATA_W | Registered read data to the bus |
| full | output | 1 | Occupancy equals DEPTH |
| half_full | output | 1 | Occupancy is at least DEPTH/2 |

## Verification
The bench sweeps every setup, strobe and hold length from one to three cycles and pushes and pops a word under each timing. A design that sampled the strobe level instead of its first clock would push or pop more than once. That would push `half_full` up early or make read data skip words. The bench fills the buffer past full and reads it past empty. A design without those guards would overwrite the oldest word, wrap its pointers, or corrupt the registered data. Strobes with the chip select high must leave everything alone. A decode that dropped the chip-select term would shift data in or out.

// File: rtl/membus_fifo_port.sv
module membus_fifo_port #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              bus_re_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              full,
  output logic              half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] LVL_HALF = (AW+1)'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level;
  logic          push_req, pop_req, push_seen, pop_seen;
  logic          do_push, do_pop, empty;

  assign push_req = ~(bus_cs_n | bus_we_n);
  assign pop_req  = ~(bus_cs_n | bus_re_n);
  assign empty     = (level == '0);
  assign full      = (level == LVL_FULL);
  assign half_full = (level >= LVL_HALF);
  assign do_push  = push_req & ~push_seen & ~full;
  assign do_pop   = pop_req  & ~pop_seen  & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_seen <= 1'b0;
      pop_seen  <= 1'b0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      bus_rdata <= '0;
    end else begin
      push_seen <= push_req;
      pop_seen  <= pop_req;
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr    <= rd_ptr + 1'b1;
        bus_rdata <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_single_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_seen && !pop_req) |=> $stable(level));

  assert_cs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |=> ($stable(level) && $stable(bus_rdata)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |=> ($stable(wr_ptr) && full));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_req) |=> ($stable(rd_ptr) && $stable(bus_rdata)));

  assert_flag_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> half_full);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_req && !pop_seen) |=> $stable(bus_rdata));
endmodule

// File: tb/membus_fifo_port_bench.sv
module membus_fifo_port_bench;
  localparam int DW = 64;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, re_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic full, half_full;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];
  int head = 0, tail = 0, occ = 0, seq = 0;
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  membus_fifo_port #(.DATA_W(DW), .DEPTH(DEPTH)) u_membus_fifo_port (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_re_n(re_n),
    .bus_wdata(wdata), .bus_rdata(rdata), .full(full), .half_full(half_full));

  function automatic logic [DW-1:0] word(input int i);
    return {32'(i) * 32'h9E3779B9, ~32'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(full == (occ == DEPTH), req, {63'd0, full}, {63'd0, occ == DEPTH});
    chk(half_full == (occ >= DEPTH/2), req, {63'd0, half_full}, {63'd0, occ >= DEPTH/2});
  endtask

  task automatic bus_write(input logic [DW-1:0] d, input int su, input int st, input int ho, input bit sel);
    @(negedge clk);
    cs_n = ~sel; we_n = 1'b1; wdata = d;
    repeat (su - 1) @(negedge clk);
    @(negedge clk) we_n = 1'b0;
    repeat (st) @(negedge clk);
    we_n = 1'b1;
    repeat (ho) @(negedge clk);
    cs_n = 1'b1;
    if (sel && occ < DEPTH) begin
      model[tail] = d; tail = (tail + 1) % DEPTH; occ++;
    end
  endtask

  task automatic bus_read(input int su, input int st, input int ho, input bit sel, input string req);
    logic [DW-1:0] mid;
    @(negedge clk);
    cs_n = ~sel; re_n = 1'b1;
    repeat (su - 1) @(negedge clk);
    @(negedge clk) re_n = 1'b0;
    @(negedge clk);
    mid = rdata;
    repeat (st - 1) @(negedge clk);
    re_n = 1'b1;
    repeat (ho) @(negedge clk);
    cs_n = 1'b1;
    if (sel && occ > 0) begin
      last_rd = model[head]; head = (head + 1) % DEPTH; occ--;
    end
    chk(mid == last_rd, req, mid, last_rd);
    chk(rdata == last_rd, {req, " R8 hold"}, rdata, last_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata == '0, "R9 rdata", rdata, '0);
    chk_flags("R9 flags");
    rst_n = 1'b1;
    @(negedge clk);

    // R10: every phase length combination, one push and one pop each
    for (int su = 1; su <= 3; su++)
      for (int st = 1; st <= 3; st++)
        for (int ho = 1; ho <= 3; ho++) begin
          bus_write(word(seq++), su, st, ho, 1'b1);
          chk_flags("R10 write");
          bus_read(ho, st, su, 1'b1, "R10 read");
          chk_flags("R10 read");
        end

    // R1: long strobes push once each
    for (int i = 0; i < DEPTH/2 - 1; i++) begin
      bus_write(word(seq++), 1, 5, 1, 1'b1);
      chk_flags("R1 long strobe");
    end

    // R6/R7: fill to full, checking flags at every level
    while (occ < DEPTH) begin
      bus_write(word(seq++), 2, 1, 2, 1'b1);
      chk_flags("R6 R7 fill");
    end

    // R4: writes while full are dropped
    for (int i = 0; i < 3; i++) begin
      bus_write(word(1000 + i), 1, 2, 1, 1'b1);
      chk_flags("R4 full write");
    end

    // R3: strobes with chip select high
    bus_write(word(2000), 1, 2, 1, 1'b0);
    chk_flags("R3 write cs high");
    bus_read(1, 2, 1, 1'b0, "R3 read cs high");
    chk_flags("R3 read cs high");

    // R2: long read strobes pop once each, in order
    while (occ > 0) begin
      bus_read(1, 4, 2, 1'b1, "R2 drain order");
      chk_flags("R2 R7 drain");
    end

    // R5: reads while empty are dropped
    for (int i = 0; i < 3; i++) begin
      bus_read(1, 2, 1, 1'b1, "R5 empty read");
      chk_flags("R5 empty flags");
    end
    bus_write(word(seq++), 1, 1, 1, 1'b1);
    bus_read(1, 1, 1, 1'b1, "R5 recovery");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule